// File: doc/BRIEF.md
# Carry-Skip Adder with Zero-Carry Stage Blocks and Incrementer Correction

This block is a purely combinational adder of two unsigned operands plus a one-bit carry-in. It returns the sum and a carry-out. The operand width is split into stages of equal size. Each stage has a ripple-carry block whose own carry-in is fixed at zero. Every stage block therefore settles at the same time, without waiting for its lower neighbour.

The true carry between stages travels along a separate chain of skip cells. Each cell is an inverting compound gate: an AND-OR-invert or an OR-AND-invert. The cells alternate so that each one accepts the polarity its predecessor emits. Once the incoming carry of a stage is known, an incrementer adds it to the zero-carry partial sum to form the final bits of that stage.

The block is meant to sit on a datapath, for example as the accumulate adder behind a multiplier, wherever a short carry path is wanted without a full prefix tree.

Top module: `cska_adder`

## Requirements
- R1: `{cout, sum}` equals `a + b + cin`, taken as a 33-bit unsigned result (DATA_W+1 bits in general), for every input combination.
- R2: Each stage block forms the sum of its slice of `a` and `b` with a carry-in of zero, whatever `cin` and the other stages hold.
- R3: A stage's zero-carry carry-out and its all-propagate signal (every bit of `a ^ b` set in the slice) are never both 1.
- R4: A stage's outgoing true carry is its zero-carry carry-out when the stage is not all-propagate. When the stage is all-propagate, the outgoing true carry equals the incoming true carry.
- R5: Skip cells alternate by stage index, counted from 0 at the least significant stage. An even-indexed stage takes a true carry through an AND-OR-invert cell and emits the complement. An odd-indexed stage takes that complement through an OR-AND-invert cell and emits a true carry. `cout` is always presented in true polarity.
- R6: The result bits of each stage equal its zero-carry partial sum plus the stage's incoming true carry, modulo 2^STAGE_W.
- R7: `cin` = 1 raises the result by exactly one: 2159 + 9542 gives 11701 with `cin` = 0 and 11702 with `cin` = 1, and 325 + 438 gives 763 and 764.
- R8: A carry that runs the full width is delivered. All-ones plus one gives `sum` = 0 with `cout` = 1. All-ones plus all-ones with `cin` = 1 gives all-ones with `cout` = 1.
- R9: The stage size STAGE_W is a parameter that divides DATA_W. With the defaults (32, 4) there are 8 stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | DATA_W (32) | First addend |
| b | input | DATA_W (32) | Second addend |
| cin | input | 1 | Carry into the least significant bit |
| sum | output | DATA_W (32) | Sum bits |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
A skip cell with the wrong polarity, or one fed from the wrong gate form, has a visible effect. It inverts the carry that enters every stage above it, so a whole run of nibbles in `sum` is off by one. This happens in the same evaluation, because nothing in the block is stored. An incrementer that ignores its carry, or a stage block with a carry-in that is not zero, shows up only on vectors that place a carry at that particular stage boundary. For that reason the stimulus adds patterns that generate, propagate or kill at chosen stages to the random mix. Vectors that are all-propagate over the full width push one carry through every cell, so any single bad cell flips `cout` or the top bits.

// File: rtl/cska_pkg.sv
// Package: shared types for the carry-skip adder.
// Assumes stage indices count from 0 at the least significant stage.
package cska_pkg;

    // Polarity of a carry wire on the skip chain
    typedef enum logic {
        POL_TRUE = 1'b0,
        POL_INV  = 1'b1
    } carry_pol_e;

    // Polarity expected at the input of stage k (even: true, odd: inverted)
    function automatic carry_pol_e stage_in_pol(input int k);
        return (k % 2 == 0) ? POL_TRUE : POL_INV;
    endfunction

endpackage

// File: rtl/cska_zero_block.sv
// Module: ripple-carry block for one stage, with its carry-in tied to zero.
// Produces the partial sum, the block carry-out and the all-propagate flag.
// Assumes W >= 1. Purely combinational.
module cska_zero_block #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] psum,
    output logic         gen,
    output logic         prop
);
    logic [W:0]   rip;
    logic [W-1:0] half;

    assign rip[0] = 1'b0;
    assign half   = a ^ b;

    // Ripple chain starting from zero carry
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign psum[i]  = half[i] ^ rip[i];
        assign rip[i+1] = (a[i] & b[i]) | (half[i] & rip[i]);
    end

    assign gen  = rip[W];
    assign prop = &half;

    // Check the block against a plain zero-carry addition
    always_comb begin
        if (!$isunknown({a, b})) begin
            AST_BLOCK_ZERO_CIN: assert ({gen, psum} == ({1'b0, a} + {1'b0, b})); // R2
            AST_GEN_PROP_EXCL: assert (!(gen && prop)); // R3
        end
    end
endmodule

// File: rtl/cska_skip_cell.sv
// Module: inverting skip cell on the inter-stage carry chain.
// IN_POL = POL_TRUE: AND-OR-invert, true carry in, complemented carry out.
// IN_POL = POL_INV : OR-AND-invert, complemented carry in, true carry out.
// Assumes gen and prop come from a zero-carry stage block.
module cska_skip_cell #(
    parameter cska_pkg::carry_pol_e IN_POL = cska_pkg::POL_TRUE
) (
    input  logic gen,
    input  logic prop,
    input  logic c_in,
    output logic c_out
);
    import cska_pkg::*;

    logic t_in;
    logic t_out;

    if (IN_POL == POL_TRUE) begin : g_aoi
        // AOI form: complement of gen | (prop & carry)
        assign c_out = ~(gen | (prop & c_in));
        assign t_in  = c_in;
        assign t_out = ~c_out;
    end else begin : g_oai
        // OAI form on the inverted carry: true carry restored
        assign c_out = ~(~gen & (~prop | c_in));
        assign t_in  = ~c_in;
        assign t_out = c_out;
    end

    // Skip and generate behaviour in true polarity
    always_comb begin
        if (!$isunknown({gen, prop, c_in})) begin
            if (prop) AST_SKIP_PASSES: assert (t_out == t_in); // R4
            if (!prop) AST_SKIP_LOCAL: assert (t_out == gen); // R4
        end
    end
endmodule

// File: rtl/cska_incr.sv
// Module: incrementer that adds the incoming stage carry to a partial sum.
// Uses an AND prefix over the partial-sum bits. Any carry out of it is dropped,
// because the skip chain already accounts for it.
module cska_incr #(
    parameter int W = 4
) (
    input  logic [W-1:0] psum,
    input  logic         cy,
    output logic [W-1:0] sum
);
    logic [W:0]   run;
    logic [W-1:0] want;

    assign run[0] = cy;

    // Toggle mask: bit i flips when carry and all lower bits are 1
    for (genvar i = 0; i < W; i++) begin : g_run
        assign run[i+1] = run[i] & psum[i];
    end

    assign sum = psum ^ run[W-1:0];

    // Compare against a plain increment
    always_comb begin
        want = psum + {{(W-1){1'b0}}, cy};
        if (!$isunknown({psum, cy})) begin
            AST_INCR_SUM: assert (sum == want); // R6
        end
    end
endmodule

// File: rtl/cska_adder.sv
// Module: top of the carry-skip adder. Stages of STAGE_W bits with zero-carry
// blocks, an alternating AOI/OAI skip chain and per-stage incrementers.
// Assumes STAGE_W divides DATA_W. Purely combinational: no clock and no reset.
module cska_adder #(
    parameter int DATA_W  = 32,
    parameter int STAGE_W = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);
    import cska_pkg::*;

    localparam int NSTAGE = DATA_W / STAGE_W;

    // link[k] is the carry entering stage k, in the polarity that stage expects
    logic [NSTAGE:0]   link;
    logic [DATA_W:0]   golden;

    assign link[0] = cin;

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        localparam carry_pol_e POL = stage_in_pol(k);
        logic [STAGE_W-1:0] ps;
        logic               g;
        logic               p;
        logic               c_true;

        cska_zero_block #(.W(STAGE_W)) u_blk (
            .a    (a[k*STAGE_W +: STAGE_W]),
            .b    (b[k*STAGE_W +: STAGE_W]),
            .psum (ps),
            .gen  (g),
            .prop (p)
        );

        cska_skip_cell #(.IN_POL(POL)) u_skip (
            .gen   (g),
            .prop  (p),
            .c_in  (link[k]),
            .c_out (link[k+1])
        );

        // Restore true polarity for the incrementer
        assign c_true = (POL == POL_TRUE) ? link[k] : ~link[k];

        cska_incr #(.W(STAGE_W)) u_inc (
            .psum (ps),
            .cy   (c_true),
            .sum  (sum[k*STAGE_W +: STAGE_W])
        );
    end

    // Final carry: odd stage count leaves the chain complemented
    if (NSTAGE % 2 == 0) begin : g_cout_even
        assign cout = link[NSTAGE];
    end else begin : g_cout_odd
        assign cout = ~link[NSTAGE];
    end

    // End-to-end check against a full-width addition
    always_comb begin
        golden = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        if (!$isunknown({a, b, cin})) begin
            AST_FULL_SUM: assert ({cout, sum} == golden); // R1
        end
    end
endmodule

// File: tb/tb_cska_adder.sv
// Bench: directed corners plus seeded random vectors, checked against a+b+cin.
module tb_cska_adder;
    localparam int  DATA_W     = 32;
    localparam int  STAGE_W    = 4;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic [DATA_W-1:0] a, b, sum;
    logic              cin, cout;
    int                n_checks = 0;
    int                n_fail   = 0;
    bit                done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cska_adder #(.DATA_W(DATA_W), .STAGE_W(STAGE_W)) dut (
        .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
    );

    // Expected result from the arithmetic definition
    function automatic logic [DATA_W:0] model(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] y,
                                              input logic c);
        return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, c};
    endfunction

    // Drive on the falling edge, sample a quarter period after the rising edge
    task automatic apply(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y,
                         input logic c, input string req);
        logic [DATA_W:0] exp_v;
        @(negedge clk);
        a = x; b = y; cin = c;
        @(posedge clk);
        #(CLK_PERIOD/4);
        exp_v = model(x, y, c);
        n_checks++;
        if ({cout, sum} !== exp_v) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h cin=%b got %b_%h expected %b_%h",
                     req, x, y, c, cout, sum, exp_v[DATA_W], exp_v[DATA_W-1:0]);
        end
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        // Idle state: zero in, zero out (R1)
        apply('0, '0, 1'b0, "R1 zero");
        // Worked examples (R7)
        apply(32'd2159, 32'd9542, 1'b0, "R7 2159+9542");
        apply(32'd2159, 32'd9542, 1'b1, "R7 2159+9542+1");
        apply(32'd325,  32'd438,  1'b0, "R7 325+438");
        apply(32'd325,  32'd438,  1'b1, "R7 325+438+1");
        // Full-width carry runs (R8)
        apply(32'hFFFF_FFFF, 32'd1, 1'b0, "R8 ones+1");
        apply(32'hFFFF_FFFF, 32'd0, 1'b1, "R8 ones+cin");
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R8 ones+ones+cin");
        // Every stage all-propagate, no generate (R3, R4)
        apply(32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b0, "R3 prop no carry");
        apply(32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b1, "R4 skip all stages");
        // Every stage generates with zero block carry-in (R2)
        apply(32'h8888_8888, 32'h8888_8888, 1'b0, "R2 each stage gen");
        apply(32'h7777_7777, 32'h1111_1111, 1'b1, "R2 inner ripple");
        // Carry born in stage 0 crosses an even then an odd cell (R5)
        apply(32'h000F_F00F, 32'h0000_0001, 1'b0, "R5 even-odd crossing");
        apply(32'h00FF_F0F0, 32'h0000_0010, 1'b0, "R5 odd-even crossing");
        // Incrementer wrap inside a stage with kill above (R6)
        apply(32'h0000_0F0F, 32'h0000_00F1, 1'b0, "R6 stage wrap");
        // Single-stage shapes walked over every stage (R9)
        for (int k = 0; k < DATA_W / STAGE_W; k++) begin
            apply(32'hF << (k*STAGE_W), 32'h1 << (k*STAGE_W), 1'b0, "R9 stage walk");
        end
        // Random vectors from a fixed seed (R1)
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 3000; i++) begin
            apply($urandom, $urandom, 1'($urandom), "R1 random");
        end
        // Random all-propagate patterns with sparse generates (R4)
        for (int i = 0; i < 500; i++) begin
            logic [DATA_W-1:0] x;
            x = $urandom;
            apply(x, ~x ^ (32'h1 << ($urandom % DATA_W)), 1'($urandom), "R4 near-propagate");
        end
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule